// File: doc/BRIEF.md
# SMBus Packet Error Code Engine

This block keeps a running CRC-8 over every byte that crosses a two-wire serial bus, with generator x^8 + x^2 + x + 1. The address byte is folded in like any other byte. The bus timing engine sits outside the block. Each time that engine moves a byte, it presents the byte with a one-cycle strobe. It also signals each start or repeated start, so that the code restarts at zero for every message.

The error code goes in the byte position that follows the last data byte, which is called the code slot here. A software request arms that slot. In DMA mode, the final byte of the DMA count arms it without any request. When the block transmits, the slot byte it offers is the computed code. When it receives, the slot byte is compared with the code computed before that byte arrived. A mismatch sets a sticky error flag that only an explicit clear removes.

A state machine with four states controls the block:
- `PEC_OFF`: the enable is low and the code is held at zero.
- `PEC_RUN`: bytes are folded into the code.
- `PEC_SLOT`: the next byte is the code byte.
- `PEC_DONE`: the code byte has passed, and bytes are ignored until the next start.

The transitions are:
- `enable_drop`: any state goes to OFF.
- `enable_rise`: OFF goes to RUN.
- `arm`: RUN goes to SLOT, on a request or on the DMA last byte.
- `slot_byte`: SLOT goes to DONE.
- `restart`: SLOT or DONE goes to RUN when a start is seen.

Top module: `pec_engine`

## Requirements
- R1: After reset, `pec_code` is 0x00, `pec_err` is 0, `pec_slot` is 0, `pec_tx_vld` is 0 and `pec_tx_byte` is 0x00.
- R2: While `pec_en` is 0, `pec_code` reads 0x00 from the next cycle on, strobed bytes have no effect on it, and `pec_slot` is 0.
- R3: With `pec_en` at 1 and the state OFF or RUN, each `byte_vld` strobe updates the code one cycle later. The byte is shifted in MSB first with polynomial 0x07 starting from the previous code, so the string "123456789" gives 0xF4.
- R4: A `bus_start` pulse clears the code to 0x00 in any enabled state and returns the state to RUN. A byte strobed in the same cycle is folded onto 0x00.
- R5: In OFF or RUN, a `pec_req` pulse sets `pec_slot` one cycle later. While the slot is armed and `dir_tx` is 1, `pec_tx_vld` is 1 and `pec_tx_byte` equals `pec_code`. Otherwise `pec_tx_byte` is 0x00.
- R6: In OFF or RUN with `dma_mode` at 1, a strobed byte that carries `dma_last` is folded and then arms the slot without a request. `dma_last` has no arming effect when `dma_mode` is 0.
- R7: When a byte is strobed in the slot with `dir_tx` at 0, and it differs from `pec_code`, `pec_err` is 1 from the next cycle. A matching byte leaves `pec_err` unchanged. The slot byte is never folded into `pec_code`, whether the block is sending or receiving.
- R8: After the slot byte, `pec_slot` drops and the state is DONE. Further bytes leave `pec_code` unchanged until the next `bus_start`.
- R9: `pec_err` stays 1 until an `err_clr` pulse clears it. A mismatch in the same cycle as `err_clr` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pec_en | input | 1 | Enables code calculation |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| byte_vld | input | 1 | One-cycle strobe: a byte crossed the bus |
| byte_data | input | 8 | Byte that crossed the bus |
| dir_tx | input | 1 | 1 = block is transmitting, 0 = receiving |
| pec_req | input | 1 | Request: next byte is the code byte |
| dma_mode | input | 1 | Transfer is driven by DMA |
| dma_last | input | 1 | Strobed byte is the final byte of the DMA count |
| err_clr | input | 1 | Clears the error flag |
| pec_code | output | 8 | Running code |
| pec_slot | output | 1 | The next byte is the code byte |
| pec_tx_vld | output | 1 | Code byte is offered for transmission |
| pec_tx_byte | output | 8 | Code byte to insert, 0x00 when not offered |
| pec_err | output | 1 | Sticky code mismatch flag |

## Verification
The assertions assume that every control input is a clean synchronous level or pulse. They also assume that `dir_tx` stays steady while a slot byte is strobed. No assumption is made about how requests, starts and bytes are ordered, so requests, DMA last bytes, starts and clears may coincide freely. The random stimulus draws every input independently on every cycle, including cycles where a start coincides with a byte or where the enable drops in the middle of a message. About half of the received slot bytes are made equal to the modelled code, so both the match path and the mismatch path of the comparison are covered.

// File: rtl/pec_pkg.sv
package pec_pkg;
    typedef enum logic [1:0] {
        PEC_OFF  = 2'd0,
        PEC_RUN  = 2'd1,
        PEC_SLOT = 2'd2,
        PEC_DONE = 2'd3
    } pec_state_e;
endpackage

// File: rtl/pec_byte_fold.sv
module pec_byte_fold #(
    parameter int          CODE_W = 8,
    parameter logic [CODE_W-1:0] POLY = 8'h07
) (
    input  logic [CODE_W-1:0] crc_in,
    input  logic [CODE_W-1:0] data_in,
    output logic [CODE_W-1:0] crc_out
);
    localparam int STEPS = CODE_W;

    logic [CODE_W-1:0] stage [0:STEPS];

    assign stage[0] = crc_in ^ data_in;

    genvar i;
    generate
        for (i = 0; i < STEPS; i++) begin : g_step
            assign stage[i+1] = stage[i][CODE_W-1]
                              ? ((stage[i] << 1) ^ POLY)
                              : (stage[i] << 1);
        end
    endgenerate

    assign crc_out = stage[STEPS];
endmodule

// File: rtl/pec_sticky_flag.sv
module pec_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R9: the flag only falls through an explicit clear
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

    // R9: a set wins over a clear in the same cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
endmodule

// File: rtl/pec_engine.sv
module pec_engine #(
    parameter int                CODE_W = 8,
    parameter logic [CODE_W-1:0] POLY   = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pec_en,
    input  logic              bus_start,
    input  logic              byte_vld,
    input  logic [CODE_W-1:0] byte_data,
    input  logic              dir_tx,
    input  logic              pec_req,
    input  logic              dma_mode,
    input  logic              dma_last,
    input  logic              err_clr,
    output logic [CODE_W-1:0] pec_code,
    output logic              pec_slot,
    output logic              pec_tx_vld,
    output logic [CODE_W-1:0] pec_tx_byte,
    output logic              pec_err
);
    import pec_pkg::*;

    localparam logic [CODE_W-1:0] CODE_ZERO = '0;

    pec_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic [CODE_W-1:0] fold_base, fold_res;
    logic              run_branch;
    logic              arm_now;
    logic              mismatch;

    // Base for folding: a start restarts the code from zero
    assign run_branch = (state_q == PEC_OFF) || (state_q == PEC_RUN) || bus_start;
    assign fold_base  = bus_start ? CODE_ZERO : code_q;
    assign arm_now    = pec_req || (dma_mode && dma_last && byte_vld);

    pec_byte_fold #(.CODE_W(CODE_W), .POLY(POLY)) u_fold (
        .crc_in  (fold_base),
        .data_in (byte_data),
        .crc_out (fold_res)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        if (!pec_en) begin
            state_d = PEC_OFF;
            code_d  = CODE_ZERO;
        end else if (run_branch) begin
            code_d  = byte_vld ? fold_res : fold_base;
            state_d = arm_now ? PEC_SLOT : PEC_RUN;
        end else begin
            unique case (state_q)
                PEC_SLOT: if (byte_vld) state_d = PEC_DONE;
                PEC_DONE: state_d = PEC_DONE;
                default:  state_d = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PEC_OFF;
            code_q  <= CODE_ZERO;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    assign mismatch = pec_en && !run_branch && (state_q == PEC_SLOT) &&
                      byte_vld && !dir_tx && (byte_data != code_q);

    pec_sticky_flag u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (mismatch),
        .clr_i  (err_clr),
        .flag_o (pec_err)
    );

    // Outputs
    always_comb begin
        pec_code    = code_q;
        pec_slot    = 1'b0;
        pec_tx_vld  = 1'b0;
        pec_tx_byte = CODE_ZERO;
        unique case (state_q)
            PEC_SLOT: begin
                pec_slot = 1'b1;
                if (dir_tx) begin
                    pec_tx_vld  = 1'b1;
                    pec_tx_byte = code_q;
                end
            end
            PEC_OFF, PEC_RUN, PEC_DONE: pec_slot = 1'b0;
            default: pec_slot = 1'b0;
        endcase
    end

    // R2: disabling clears the code
    a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pec_en |=> (pec_code == CODE_ZERO && !pec_slot));

    // R4: a start without a byte leaves a zero code
    a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_en && bus_start && !byte_vld) |=> (pec_code == CODE_ZERO));

    // R6: DMA last byte arms the slot
    a_r6_dma_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_en && run_branch && byte_vld && dma_mode && dma_last) |=> pec_slot);

    // R7: the slot byte is not folded
    a_r7_slot_no_fold: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_en && pec_slot && byte_vld && !bus_start) |=> $stable(pec_code));

    // R8: the slot closes after its byte
    a_r8_slot_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_en && pec_slot && byte_vld && !bus_start) |=> !pec_slot);

    // R5: the offered byte follows the code
    a_r5_tx_byte: assert property (@(posedge clk) disable iff (!rst_n)
        pec_tx_vld |-> (pec_slot && pec_tx_byte == pec_code));
endmodule

// File: tb/pec_engine_test.sv
module pec_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pec_en = 1'b0, bus_start = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       dir_tx = 1'b0, pec_req = 1'b0, dma_mode = 1'b0, dma_last = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] pec_code, pec_tx_byte;
    logic       pec_slot, pec_tx_vld, pec_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model: 0 off, 1 run, 2 slot, 3 done
    int       mst = 0;
    logic [7:0] mcode = 8'h00;
    logic       merr = 1'b0;

    always #4 clk = ~clk;

    pec_engine uut (
        .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .bus_start(bus_start),
        .byte_vld(byte_vld), .byte_data(byte_data), .dir_tx(dir_tx),
        .pec_req(pec_req), .dma_mode(dma_mode), .dma_last(dma_last),
        .err_clr(err_clr), .pec_code(pec_code), .pec_slot(pec_slot),
        .pec_tx_vld(pec_tx_vld), .pec_tx_byte(pec_tx_byte), .pec_err(pec_err)
    );

    function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3 code", pec_code, mcode);
        chk("R5 slot", {7'd0, pec_slot}, {7'd0, mst == 2});
        chk("R5 tx_vld", {7'd0, pec_tx_vld}, {7'd0, mst == 2 && dir_tx});
        chk("R5 tx_byte", pec_tx_byte, (mst == 2 && dir_tx) ? mcode : 8'h00);
        chk("R9 err", {7'd0, pec_err}, {7'd0, merr});
    endtask

    // apply one cycle (called at negedge), update model, compare at next negedge
    task automatic tick(input logic en, input logic st, input logic vld,
                        input logic [7:0] d, input logic tx, input logic req,
                        input logic dma, input logic last, input logic clr);
        logic       run_br;
        logic [7:0] base;
        logic       set_e;
        int         nst;
        logic [7:0] ncode;
        pec_en = en; bus_start = st; byte_vld = vld; byte_data = d;
        dir_tx = tx; pec_req = req; dma_mode = dma; dma_last = last; err_clr = clr;
        run_br = (mst == 0) || (mst == 1) || st;
        set_e  = 1'b0;
        nst    = mst;
        ncode  = mcode;
        if (!en) begin
            nst = 0; ncode = 8'h00;
        end else if (run_br) begin
            base  = st ? 8'h00 : mcode;
            ncode = vld ? crc_ref(base, d) : base;
            nst   = (req || (dma && last && vld)) ? 2 : 1;
        end else if (mst == 2 && vld) begin
            if (!tx && d != mcode) set_e = 1'b1;
            nst = 3;
        end
        if (set_e) merr = 1'b1;
        else if (clr) merr = 1'b0;
        mst = nst;
        mcode = ncode;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle1();
        tick(pec_en, 0, 0, 8'h00, dir_tx, 0, 0, 0, 0);
    endtask

    task automatic send(input logic [7:0] d);
        tick(1, 0, 1, d, dir_tx, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ascii [0:8];
        logic [7:0] saved;
        void'($urandom(32'h5EC0DE));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 code", pec_code, 8'h00);
        chk("R1 err", {7'd0, pec_err}, 8'h00);
        chk("R1 slot", {7'd0, pec_slot}, 8'h00);
        chk("R1 tx", {7'd0, pec_tx_vld}, 8'h00);
        chk("R1 txbyte", pec_tx_byte, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled, bytes ignored
        tick(0, 0, 1, 8'hA5, 0, 0, 0, 0, 0);
        chk("R2 off code", pec_code, 8'h00);
        tick(0, 0, 1, 8'h3C, 0, 1, 0, 0, 0);
        chk("R2 off slot", {7'd0, pec_slot}, 8'h00);

        // R3: known string check value
        for (int i = 0; i < 9; i++) ascii[i] = 8'h31 + 8'(i);
        tick(1, 1, 0, 8'h00, 1, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) send(ascii[i]);
        chk("R3 check value", pec_code, 8'hF4);

        // R5 and R10-like: transmit slot, code byte not folded (R7)
        tick(1, 0, 0, 8'h00, 1, 1, 0, 0, 0);
        chk("R5 tx armed", pec_tx_byte, 8'hF4);
        tick(1, 0, 1, 8'hF4, 1, 0, 0, 0, 0);
        chk("R7 tx slot byte not folded", pec_code, 8'hF4);
        // R8: bytes ignored after slot
        tick(1, 0, 1, 8'h11, 1, 0, 0, 0, 0);
        chk("R8 done ignores", pec_code, 8'hF4);

        // R4: start with byte folds onto zero
        tick(1, 1, 1, 8'h5A, 0, 0, 0, 0, 0);
        chk("R4 start+byte", pec_code, crc_ref(8'h00, 8'h5A));
        tick(1, 1, 0, 8'h00, 0, 0, 0, 0, 0);
        chk("R4 start clears", pec_code, 8'h00);

        // R6: DMA last arms, receive mismatch sets error (R7)
        send(8'hA0);
        tick(1, 0, 1, 8'h01, 0, 0, 1, 1, 0);
        chk("R6 dma armed", {7'd0, pec_slot}, 8'h01);
        saved = pec_code;
        tick(1, 0, 1, saved ^ 8'h01, 0, 0, 0, 0, 1);
        chk("R9 set wins over clear", {7'd0, pec_err}, 8'h01);
        chk("R7 rx byte not folded", pec_code, saved);
        idle1();
        chk("R9 sticky", {7'd0, pec_err}, 8'h01);
        tick(1, 0, 0, 8'h00, 0, 0, 0, 0, 1);
        chk("R9 cleared", {7'd0, pec_err}, 8'h00);

        // R6: dma_last without dma_mode does not arm
        tick(1, 1, 1, 8'h77, 0, 0, 0, 1, 0);
        chk("R6 no dma no arm", {7'd0, pec_slot}, 8'h00);
        // R7: matching byte leaves error clear
        tick(1, 0, 0, 8'h00, 0, 1, 0, 0, 0);
        tick(1, 0, 1, mcode, 0, 0, 0, 0, 0);
        chk("R7 match no error", {7'd0, pec_err}, 8'h00);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic       en, st, vld, tx, req, dma, last, clr;
            logic [7:0] d;
            en   = ($urandom % 16) != 0;
            st   = ($urandom % 10) == 0;
            vld  = ($urandom % 2) == 0;
            tx   = ($urandom % 2) == 0;
            req  = ($urandom % 12) == 0;
            dma  = ($urandom % 2) == 0;
            last = ($urandom % 6) == 0;
            clr  = ($urandom % 10) == 0;
            d    = 8'($urandom);
            if (mst == 2 && ($urandom % 2) == 0) d = mcode;
            tick(en, st, vld, d, tx, req, dma, last, clr);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule